// File: doc/BRIEF.md
# Separate-Port Burst-of-Two SRAM Model

A synthesizable behavioural model of a synchronous static RAM with independent read and write data ports. Every command moves exactly two data beats, and the model runs on a beat-rate clock: one clock cycle carries one data beat. Reads and writes share one command address bus. The bus is time-sliced into alternating beat phases. Reads are accepted only on the even phase and writes only on the odd phase. So a read burst and a write burst can both be in flight at the same time.

The external address has one bit fewer than the word address. The model appends the low word-address bit itself, using 0 for the first beat and 1 for the second. Write data is qualified per beat by one enable per 9-bit lane. Read data leaves through an output register that loads on every cycle or only when an output-clock tick is present, as a mode input selects. A read that meets a write to the same word on the same clock edge sees the freshly written lanes.

The storage is one small RAM per byte lane, so each lane can map onto a block memory.

Top module: `sio_b2_sram`

## Requirements
- R1: A read burst and a write burst can be in progress on the same cycles. Each completes exactly as it would alone: read beats appear on `rd_data` while write beats are being taken on `wr_data`.
- R2: The first cycle after reset is the even phase, and the phase alternates every cycle. `rd_req` is accepted only on the even phase and `wr_req` only on the odd phase. A request on the other phase has no effect: it produces no read beat and it changes no stored word.
- R3: A read accepted in cycle n with address `a` drives word `{a,0}` in cycle n+2 and word `{a,1}` in cycle n+3, with `rd_valid` high in both cycles. While the output register loads, `rd_valid` is low in every other cycle.
- R4: A write accepted in cycle n with address `a` stores the `wr_data` of cycle n+1 into word `{a,0}` and the `wr_data` of cycle n+2 into word `{a,1}`.
- R5: `wr_be[i]` qualifies bits `[9*i+8 : 9*i]` of the beat it accompanies. A lane whose enable is low keeps its stored value. The two beats of one burst may carry different enables.
- R6: A read of a word receives that word's newly written lanes, merged with its unwritten lanes, when the read is accepted in the cycle right after the write that targets it.
- R7: With `out_sel` low, the output register loads every cycle. With `out_sel` high, it loads only in cycles where `out_tick` is high; in other cycles `rd_data` and `rd_valid` hold their values.
- R8: Synchronous reset drives `rd_valid` and `rd_data` to zero and drops every burst in flight. Stored words survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| out_sel | input | 1 | 1: output register gated by `out_tick`; 0: loads every cycle |
| out_tick | input | 1 | Output-clock tick, used when `out_sel` is 1 |
| addr | input | ADDR_W | Burst address, with the low word bit omitted |
| rd_req | input | 1 | Read request, taken on the even phase |
| wr_req | input | 1 | Write request, taken on the odd phase |
| wr_data | input | DATA_W | Write beat data |
| wr_be | input | DATA_W/LANE_W | Per-beat lane write enables |
| rd_data | output | DATA_W | Registered read beat data |
| rd_valid | output | 1 | Marks a read beat on `rd_data` |

## Verification
A read beat and a write beat can target the same word on the same clock edge. This happens when a read is accepted on the even cycle right after a write to the same address: both beat pairs then line up edge for edge. The bench provokes this collision with partial lane enables, and also inside a long stream that interleaves reads and writes on every cycle with overlapping addresses. The bench reference applies each cycle's write beat before it evaluates that cycle's read beat. Every read beat is therefore judged against the lane-merged word that includes the colliding write.

// File: rtl/sio_b2_pkg.sv
package sio_b2_pkg;
  typedef enum logic {
    PH_RD = 1'b0,
    PH_WR = 1'b1
  } beat_phase_e;
endpackage

// File: rtl/sio_b2_seq.sv
module sio_b2_seq
  import sio_b2_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic            rd_req,
  input  logic            wr_req,
  output logic            phase,
  output logic            rd_go,
  output logic [ADDR_W:0] rd_word,
  output logic            wr_go,
  output logic [ADDR_W:0] wr_word
);
  beat_phase_e ph_q;
  logic rd_acc, wr_acc;
  logic rd_pend, wr_b0, wr_b1;
  logic [ADDR_W-1:0] ra_q, wa_q;

  assign rd_acc = rd_req && (ph_q == PH_RD);
  assign wr_acc = wr_req && (ph_q == PH_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_RD;
      rd_pend <= 1'b0;
      wr_b0   <= 1'b0;
      wr_b1   <= 1'b0;
    end else begin
      ph_q    <= (ph_q == PH_RD) ? PH_WR : PH_RD;
      rd_pend <= rd_acc;
      wr_b0   <= wr_acc;
      wr_b1   <= wr_b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_acc) ra_q <= addr;
    if (wr_acc) wa_q <= addr;
  end

  always_comb begin
    phase   = (ph_q == PH_WR);
    rd_go   = rd_acc || rd_pend;
    rd_word = rd_pend ? {ra_q, 1'b1} : {addr, 1'b0};
    wr_go   = wr_b0 || wr_b1;
    wr_word = {wa_q, wr_b1};
  end
endmodule

// File: rtl/sio_b2_lane_ram.sv
module sio_b2_lane_ram #(
  parameter int AW     = 5,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sio_b2_rd_out.sv
module sio_b2_rd_out #(
  parameter int AW     = 5,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_go,
  input  logic [AW-1:0]             rd_word,
  input  logic                      wr_go,
  input  logic [AW-1:0]             wr_word,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [DATA_W/LANE_W-1:0]  wr_be,
  input  logic [DATA_W-1:0]         mem_q,
  input  logic                      out_sel,
  input  logic                      out_tick,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_valid
);
  localparam int LANES = DATA_W / LANE_W;

  logic             s1_valid;
  logic [LANES-1:0] fwd_mask;
  logic [DATA_W-1:0] fwd_data;
  logic [DATA_W-1:0] merged;
  logic             hit, load;

  assign hit  = rd_go && wr_go && (rd_word == wr_word);
  assign load = !out_sel || out_tick;

  always_ff @(posedge clk) begin
    fwd_mask <= hit ? wr_be : '0;
    fwd_data <= wr_data;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = fwd_mask[g] ? fwd_data[g*LANE_W +: LANE_W]
                                                    : mem_q[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      s1_valid <= rd_go;
      if (load) begin
        rd_valid <= s1_valid;
        rd_data  <= merged;
      end
    end
  end
endmodule

// File: rtl/sio_b2_sram.sv
module sio_b2_sram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 36,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     out_sel,
  input  logic                     out_tick,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rd_req,
  input  logic                     wr_req,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [DATA_W/LANE_W-1:0] wr_be,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     rd_valid
);
  localparam int AW    = ADDR_W + 1;
  localparam int LANES = DATA_W / LANE_W;

  logic          phase;
  logic          rd_go, wr_go;
  logic [AW-1:0] rd_word, wr_word;
  logic [DATA_W-1:0] mem_q;

  sio_b2_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .addr(addr), .rd_req(rd_req), .wr_req(wr_req),
    .phase(phase), .rd_go(rd_go), .rd_word(rd_word),
    .wr_go(wr_go), .wr_word(wr_word)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sio_b2_lane_ram #(.AW(AW), .LANE_W(LANE_W)) u_ram (
      .clk(clk),
      .we(wr_go && wr_be[g]),
      .waddr(wr_word),
      .wdata(wr_data[g*LANE_W +: LANE_W]),
      .raddr(rd_word),
      .rdata(mem_q[g*LANE_W +: LANE_W])
    );
  end

  sio_b2_rd_out #(.AW(AW), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_out (
    .clk(clk), .rst(rst), .rd_go(rd_go), .rd_word(rd_word),
    .wr_go(wr_go), .wr_word(wr_word), .wr_data(wr_data), .wr_be(wr_be),
    .mem_q(mem_q), .out_sel(out_sel), .out_tick(out_tick),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/sio_b2_sram_chk.sv
module sio_b2_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_req,
  input logic              wr_req,
  input logic              out_sel,
  input logic              out_tick,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              phase,
  input logic              wr_go
);
  logic ph, rd_acc, wr_acc, ld;

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= ~ph;
  end

  assign rd_acc = rd_req && !ph && !rst;
  assign wr_acc = wr_req && ph && !rst;
  assign ld     = !out_sel || out_tick;

  AST_PHASE_TRACK: assert property (@(posedge clk) disable iff (rst) phase == ph); // R2
  AST_RD_BEAT_FIRST: assert property (@(posedge clk) disable iff (rst)
    rd_acc ##1 ld |=> rd_valid); // R3
  AST_RD_BEAT_SECOND: assert property (@(posedge clk) disable iff (rst)
    rd_acc ##2 ld |=> rd_valid); // R3
  AST_RD_NO_STRAY: assert property (@(posedge clk) disable iff (rst)
    ld |=> (rd_valid == ($past(rd_acc, 2) || $past(rd_acc, 3)))); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld |=> ($stable(rd_data) && $stable(rd_valid))); // R7
  AST_WR_TWO_BEATS: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> wr_go ##1 wr_go); // R4
  AST_WR_NO_STRAY: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> ($past(wr_acc) || $past(wr_acc, 2))); // R2
endmodule

bind sio_b2_sram sio_b2_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
  .out_sel(out_sel), .out_tick(out_tick), .rd_data(rd_data),
  .rd_valid(rd_valid), .phase(phase), .wr_go(wr_go)
);

// File: tb/test_sio_b2_sram.sv
`timescale 1ns/1ps
module test_sio_b2_sram;
  localparam int AWX = 4;
  localparam int DW  = 36;
  localparam int LW  = 9;
  localparam int NL  = DW / LW;
  localparam int NWORD = 1 << (AWX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic out_sel = 1'b0, out_tick = 1'b0;
  logic [AWX-1:0] addr = '0;
  logic rd_req = 1'b0, wr_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [NL-1:0] wr_be = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;

  sio_b2_sram #(.ADDR_W(AWX), .DATA_W(DW), .LANE_W(LW)) i_sio_b2_sram (
    .clk(clk), .rst(rst), .out_sel(out_sel), .out_tick(out_tick),
    .addr(addr), .rd_req(rd_req), .wr_req(wr_req), .wr_data(wr_data),
    .wr_be(wr_be), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int k = 0;
  logic [DW-1:0] mdl [NWORD];
  logic [DW-1:0] exp_d [int];
  string exp_t [int];
  int wr_stage = 0, wa = 0, rd_stage = 0, ra = 0;
  string rd_tag = "";
  bit chk_en = 1'b1;
  bit hold_arm = 1'b0, hold_snap = 1'b0;
  logic [DW-1:0] snap_d;
  logic snap_v;
  logic nxt_sel = 1'b0, nxt_tick = 1'b0;

  function automatic logic [DW-1:0] dat(input int a, input int b, input int s);
    logic [DW-1:0] v;
    v = DW'(s) * 36'h0_1234_5671 + DW'(a) * 36'h0_0101_0103 + DW'(b) * 36'h7_0000_0777;
    return v ^ 36'h5_A5C3_3C5A;
  endfunction

  task automatic cyc(input bit rq, input bit wq, input int a,
                     input logic [DW-1:0] wd, input logic [NL-1:0] be, input string tag);
    int w;
    @(negedge clk);
    if (hold_arm && !hold_snap) begin
      snap_d = rd_data; snap_v = rd_valid; hold_snap = 1'b1;
    end else if (hold_arm) begin
      checks++;
      if (rd_data !== snap_d || rd_valid !== snap_v) begin
        errors++;
        $display("FAIL R7: hold broken rd_valid=%0b rd_data=%h expected %0b %h",
                 rd_valid, rd_data, snap_v, snap_d);
      end
    end else if (chk_en) begin
      checks++;
      if (exp_d.exists(k)) begin
        if (rd_valid !== 1'b1 || rd_data !== exp_d[k]) begin
          errors++;
          $display("FAIL %s: cycle %0d rd_valid=%0b rd_data=%h expected 1 %h",
                   exp_t[k], k, rd_valid, rd_data, exp_d[k]);
        end
      end else if (rd_valid !== 1'b0) begin
        errors++;
        $display("FAIL R3: cycle %0d rd_valid=%0b expected 0", k, rd_valid);
      end
    end
    rd_req = rq; wr_req = wq; addr = AWX'(a); wr_data = wd; wr_be = be;
    out_sel = nxt_sel; out_tick = nxt_tick;
    // reference: this cycle's write beat lands before this cycle's read beat
    if (wr_stage > 0) begin
      w = wa * 2 + (wr_stage - 1);
      for (int i = 0; i < NL; i++)
        if (be[i]) mdl[w][i*LW +: LW] = wd[i*LW +: LW];
      wr_stage = (wr_stage == 1) ? 2 : 0;
    end
    if (rd_stage == 1) begin
      exp_d[k+2] = mdl[ra*2+1]; exp_t[k+2] = rd_tag; rd_stage = 0;
    end
    if (rq && (k % 2 == 0)) begin
      ra = a; rd_tag = tag; rd_stage = 1;
      exp_d[k+2] = mdl[a*2]; exp_t[k+2] = tag;
    end
    if (wq && (k % 2 == 1)) begin
      wa = a; wr_stage = 1;
    end
    k++;
  endtask

  task automatic idle(); cyc(0, 0, 0, '0, '0, ""); endtask

  task automatic to_parity(input int p);
    if (k % 2 != p) idle();
  endtask

  task automatic wr_burst(input int a, input logic [DW-1:0] d0, input logic [NL-1:0] b0,
                          input logic [DW-1:0] d1, input logic [NL-1:0] b1);
    to_parity(1);
    cyc(0, 1, a, '0, '0, "");
    cyc(0, 0, 0, d0, b0, "");
    cyc(0, 0, 0, d1, b1, "");
  endtask

  task automatic rd_burst(input int a, input string tag);
    to_parity(0);
    cyc(1, 0, a, '0, '0, tag);
    idle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rd_req = 0; wr_req = 0; wr_data = '0; wr_be = '0;
    out_sel = 0; out_tick = 0; nxt_sel = 0; nxt_tick = 0;
    repeat (4) @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== '0) begin
      errors++;
      $display("FAIL R8: after reset rd_valid=%0b rd_data=%h expected 0 0", rd_valid, rd_data);
    end
    rst = 1'b0;
    wr_stage = 0; rd_stage = 0; exp_d.delete(); exp_t.delete();
    k = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R4: fill every word, full-lane writes
    for (int a = 0; a < NWORD / 2; a++) wr_burst(a, dat(a, 0, 1), '1, dat(a, 1, 1), '1);
    // R3 / R4: read every burst back
    for (int a = 0; a < NWORD / 2; a++) rd_burst(a, "R3");
    repeat (3) idle();
    // R5: different lane masks on the two beats
    wr_burst(3, dat(3, 0, 7), 4'b0101, dat(3, 1, 7), 4'b1010);
    wr_burst(12, dat(12, 0, 8), 4'b1000, dat(12, 1, 8), 4'b0000);
    rd_burst(3, "R5"); rd_burst(12, "R5");
    repeat (3) idle();
    // R6: read right after write to same address, partial lanes, same-edge collision
    to_parity(1);
    cyc(0, 1, 5, '0, '0, "");
    cyc(1, 0, 5, dat(5, 0, 9), 4'b0011, "R6");
    cyc(0, 0, 0, dat(5, 1, 9), 4'b1110, "");
    repeat (3) idle();
    rd_burst(5, "R6");
    repeat (3) idle();
    // R1: continuous interleaving, one read and one write in flight on every cycle
    to_parity(0);
    for (int i = 0; i < 24; i++) begin
      if (i % 2 == 0) cyc(1, 0, (i * 3) % 16, dat(i, 2, 11), NL'(i * 5 + 3), "R1");
      else            cyc(0, 1, (i * 5 + 1) % 16, dat(i, 3, 11), NL'(i * 7 + 1), "R1");
    end
    repeat (4) idle();
    for (int a = 0; a < NWORD / 2; a++) rd_burst(a, "R1");
    repeat (3) idle();
    // R2: requests on the wrong phase are ignored
    to_parity(1);
    cyc(1, 0, 9, '0, '0, "R2");
    repeat (4) idle();
    to_parity(0);
    cyc(0, 1, 7, '0, '0, "");
    cyc(0, 0, 0, '1, '1, "");
    cyc(0, 0, 0, '1, '1, "");
    repeat (2) idle();
    rd_burst(7, "R2");
    repeat (3) idle();
    // R7: gated output, ticks present every cycle behaves normally
    nxt_sel = 1'b1; nxt_tick = 1'b1;
    rd_burst(10, "R7"); rd_burst(2, "R7");
    repeat (3) idle();
    // R7: gated output without ticks holds
    to_parity(0);
    nxt_tick = 1'b0;
    hold_arm = 1'b1; hold_snap = 1'b0;
    cyc(1, 0, 14, '0, '0, "R7");
    repeat (6) idle();
    hold_arm = 1'b0;
    nxt_sel = 1'b0;
    chk_en = 1'b0;
    repeat (3) idle();
    exp_d.delete(); exp_t.delete(); rd_stage = 0;
    chk_en = 1'b1;
    repeat (2) idle();
    // R8: reset keeps stored words
    do_reset();
    for (int a = 0; a < NWORD / 2; a++) rd_burst(a, "R8");
    repeat (4) idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule